// File: doc/BRIEF.md
# I2C Master Transmitter with Pending Handshake

This block drives an I2C bus as a master transmitter under software control. Software sees four byte-wide registers: control, status/command, own address and data. To send a message, software places the target address byte in the data register and writes the command value 0xF0 to the status register. The block then issues START and shifts the byte out most significant bit first. It clocks one acknowledge slot, records the level seen on SDA, raises a pending flag and parks the bus with SCL low.

While the flag is set, software can load the next byte, or it can request STOP by writing 0xD0 to the status register. Clearing the flag releases the bus. The block then either shifts the next byte out or produces the STOP condition, after which the busy bit drops. An interrupt line follows the pending flag whenever interrupts are enabled. The SCL half-period is set by a four-bit field in system clocks, and the output enables for both lines follow the serial-output enable bit. SDA is released during each acknowledge slot.

Top module: `i2c_master_tx`

## Requirements
- R1: After reset the status and control registers read 0x00, SCL and SDA are high and the interrupt output is low.
- R2: The own-address register (register address 2) stores all eight written bits and reads them back unchanged.
- R3: Control register (address 0): bit 5 is the interrupt enable, bit 4 is the pending flag and bits 3:0 are the period field. Writing 0 to bit 4 clears the flag, and writing 1 to it leaves the flag as it is. Status register (address 1): bits 7:6 are the mode, bit 5 is busy, bit 4 is the serial-output enable and bit 0 is the last received bit. The data register is at address 3.
- R4: Writing 0xF0 to the status register while idle starts a transfer: SDA falls while SCL is high and busy reads 1. A command with bit 4 clear (for example 0xE0) starts nothing.
- R5: Each byte goes out on SDA most significant bit first, one bit per SCL high phase.
- R6: When the acknowledge high phase ends, the pending flag sets, SCL is held low until software clears the flag, and status bit 0 holds the sampled SDA level (0 for ACK, 1 for NACK).
- R7: Each SCL half-period lasts (period field + 1) × 16 system clocks.
- R8: The interrupt output is high exactly when the pending flag and the interrupt enable are both 1.
- R9: A data-register write made while busy and not pending is ignored, so the byte already in flight is sent intact.
- R10: Writing 0xD0 to the status register and then clearing the flag produces STOP: SDA rises while SCL is high, busy returns to 0 and both lines stay high.
- R11: Outside START and STOP, SDA changes only while SCL is low.
- R12: When the block sets the pending flag in the same cycle as a control write that carries 1 in bit 4, the flag still sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| scl_o | output | 1 | SCL output level |
| scl_oe | output | 1 | SCL output enable |
| sda_o | output | 1 | SDA output level |
| sda_oe | output | 1 | SDA output enable (low during the acknowledge slot) |
| sda_i | input | 1 | SDA input level |
| irq | output | 1 | Interrupt request |

## Verification
Two things can happen in the same clock cycle: the transmitter sets the pending flag at the end of an acknowledge slot, and software writes the control register. The bench provokes this by writing the control register on every cycle, with bit 4 set to 1 and interrupts enabled, for the whole span of a byte transfer. At the end it expects the flag to read 1 and the interrupt to be high, because the set takes priority over the write. It also expects the transmitted byte to be intact.

// File: rtl/i2c_master_tx.sv
module i2c_master_tx #(
  parameter int PRE_W = 4,
  parameter int SHIFT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       scl_o,
  output logic       scl_oe,
  output logic       sda_o,
  output logic       sda_oe,
  input  logic       sda_i,
  output logic       irq
);
  localparam int CW = PRE_W + SHIFT + 1;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_BLO, S_BHI, S_ALO, S_AHI, S_HOLD, S_PLO, S_PHI, S_PEND
  } st_t;

  st_t              st_q, st_d;
  logic [CW-1:0]    cnt_q, half;
  logic [PRE_W-1:0] per_q;
  logic             ien_q, pend_q, oe_q, lrb_q, stop_q;
  logic [1:0]       mode_q;
  logic [7:0]       own_q, sh_q;
  logic [2:0]       bit_q;
  logic             done, busy, start_cmd;
  logic             wr_ctl, wr_sts, wr_own, wr_dat;

  assign half = ({{(CW-PRE_W){1'b0}}, per_q} + CW'(1)) << SHIFT;
  assign done = (cnt_q == half - CW'(1));
  assign busy = (st_q != S_IDLE);

  assign wr_ctl = wr_en && (wr_addr == 2'd0);
  assign wr_sts = wr_en && (wr_addr == 2'd1);
  assign wr_own = wr_en && (wr_addr == 2'd2);
  assign wr_dat = wr_en && (wr_addr == 2'd3);
  assign start_cmd = wr_sts && (wr_data[7:6] == 2'b11) && wr_data[5] && wr_data[4] && !busy;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE:  if (start_cmd) st_d = S_START;
      S_START: if (done) st_d = S_BLO;
      S_BLO:   if (done) st_d = S_BHI;
      S_BHI:   if (done) st_d = (bit_q == 3'd7) ? S_ALO : S_BLO;
      S_ALO:   if (done) st_d = S_AHI;
      S_AHI:   if (done) st_d = S_HOLD;
      S_HOLD:  if (!pend_q) st_d = stop_q ? S_PLO : S_BLO;
      S_PLO:   if (done) st_d = S_PHI;
      S_PHI:   if (done) st_d = S_PEND;
      S_PEND:  if (done) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      per_q  <= '0;
      ien_q  <= 1'b0;
      pend_q <= 1'b0;
      oe_q   <= 1'b0;
      lrb_q  <= 1'b0;
      stop_q <= 1'b0;
      mode_q <= 2'b00;
      own_q  <= 8'h00;
      sh_q   <= 8'h00;
      bit_q  <= 3'd0;
    end else begin
      st_q  <= st_d;
      cnt_q <= (st_d != st_q) ? '0 : cnt_q + CW'(1);

      if (wr_ctl) begin
        ien_q <= wr_data[5];
        per_q <= wr_data[PRE_W-1:0];
        if (!wr_data[4]) pend_q <= 1'b0;
      end
      if (wr_sts) begin
        mode_q <= wr_data[7:6];
        oe_q   <= wr_data[4];
        if (busy && !wr_data[5]) stop_q <= 1'b1;
      end
      if (wr_own) own_q <= wr_data;
      if (wr_dat && (!busy || pend_q)) sh_q <= wr_data;

      case (st_q)
        S_IDLE:  stop_q <= 1'b0;
        S_BHI:   if (done) begin
                   sh_q  <= {sh_q[6:0], 1'b0};
                   bit_q <= bit_q + 3'd1;
                 end
        S_AHI:   if (done) begin
                   lrb_q  <= sda_i;
                   pend_q <= 1'b1;
                 end
        S_HOLD:  begin
                   bit_q <= 3'd0;
                   if (!pend_q && stop_q) stop_q <= 1'b0;
                 end
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (st_q)
      S_IDLE, S_START, S_BHI, S_AHI, S_PHI, S_PEND: scl_o = 1'b1;
      default:                                      scl_o = 1'b0;
    endcase
    unique case (st_q)
      S_START, S_PLO, S_PHI: sda_o = 1'b0;
      S_BLO, S_BHI:          sda_o = sh_q[7];
      default:               sda_o = 1'b1;
    endcase
  end

  assign scl_oe = oe_q;
  assign sda_oe = oe_q && (st_q != S_ALO) && (st_q != S_AHI);
  assign irq    = pend_q && ien_q;

  always_comb begin
    unique case (rd_addr)
      2'd0:    rd_data = {2'b00, ien_q, pend_q, {(4-PRE_W){1'b0}}, per_q};
      2'd1:    rd_data = {mode_q, busy, oe_q, 3'b000, lrb_q};
      2'd2:    rd_data = own_q;
      default: rd_data = sh_q;
    endcase
  end
endmodule

// File: rtl/i2c_master_tx_chk.sv
module i2c_master_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_o,
  input logic sda_o,
  input logic irq,
  input logic pend,
  input logic busy
);
  a_r6_scl_held_low: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> !scl_o);

  a_r6_bus_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && $past(pend)) |-> ($stable(scl_o) && $stable(sda_o)));

  a_r10_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (scl_o && sda_o));

  a_r11_fall_only_start: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_o && $past(scl_o) && $fell(sda_o)) |-> busy);

  a_r11_rise_only_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_o && $past(scl_o) && $rose(sda_o)) |-> (busy && !pend));

  a_r8_irq_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> pend);
endmodule

bind i2c_master_tx i2c_master_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_o(scl_o), .sda_o(sda_o),
  .irq(irq), .pend(pend_q), .busy(busy)
);

// File: tb/tb_i2c_master_tx.sv
module tb_i2c_master_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] rd_addr = 2'd0;
  logic [7:0] rd_data;
  logic       scl_o, scl_oe, sda_o, sda_oe, irq;
  logic       sda_i = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  i2c_master_tx dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .scl_o(scl_o), .scl_oe(scl_oe),
    .sda_o(sda_o), .sda_oe(sda_oe), .sda_i(sda_i), .irq(irq)
  );

  // {ack level, byte}
  localparam logic [8:0] VEC [4] = '{
    {1'b0, 8'hA5}, {1'b1, 8'h3C}, {1'b0, 8'hFF}, {1'b1, 8'h01}
  };

  logic [7:0] cap;
  int cap_n, start_n, stop_n, hi_len, last_hi;
  logic p_scl = 1'b1, p_sda = 1'b1;

  always @(negedge clk) begin
    if (scl_o && !p_scl && sda_oe) begin
      cap   <= {cap[6:0], sda_o};
      cap_n <= cap_n + 1;
    end
    if (scl_o && p_scl && !sda_o && p_sda) start_n <= start_n + 1;
    if (scl_o && p_scl && sda_o && !p_sda) stop_n <= stop_n + 1;
    if (scl_o) hi_len <= hi_len + 1;
    else if (p_scl) begin last_hi <= hi_len; hi_len <= 0; end
    p_scl <= scl_o;
    p_sda <= sda_o;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr = a;
    #0.5;
    d = rd_data;
  endtask

  task automatic wait_pend(output bit ok);
    logic [7:0] v;
    ok = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      rd(2'd0, v);
      if (v[4]) begin ok = 1'b1; break; end
    end
  endtask

  task automatic clr_cap();
    @(negedge clk);
    cap_n = 0;
    cap = 8'h00;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    bit ok;
    cap = 8'h00; cap_n = 0; start_n = 0; stop_n = 0; hi_len = 0; last_hi = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(2'd1, v); chk(v == 8'h00, "R1 status", v, 8'h00);
    rd(2'd0, v); chk(v == 8'h00, "R1 control", v, 8'h00);
    chk(scl_o && sda_o && !irq, "R1 lines", {scl_o, sda_o, irq}, 3'b110);

    wr(2'd2, 8'h5A);
    rd(2'd2, v); chk(v == 8'h5A, "R2 own address", v, 8'h5A);

    wr(2'd1, 8'hE0);
    repeat (5) @(negedge clk);
    rd(2'd1, v); chk(v == 8'hC0, "R4 no start without bit4", v, 8'hC0);
    chk(start_n == 0 && scl_o && sda_o, "R4 bus idle", start_n, 0);

    wr(2'd0, 8'h02);
    wr(2'd3, 8'hA0);
    sda_i = 1'b0;
    clr_cap();
    wr(2'd1, 8'hF0);
    chk(scl_o && !sda_o, "R4 start level", {scl_o, sda_o}, 2'b10);
    rd(2'd1, v); chk(v == 8'hF0, "R4 busy", v, 8'hF0);
    wait_pend(ok);
    chk(ok, "R6 pending", ok, 1);
    chk(start_n == 1, "R4 start seen", start_n, 1);
    chk(cap == 8'hA0 && cap_n == 8, "R5 address byte", cap, 8'hA0);
    chk(last_hi == 48, "R7 half period", last_hi, 48);
    rd(2'd1, v); chk(v[0] == 1'b0, "R6 ack bit", v[0], 0);
    chk(!irq, "R8 irq off when disabled", irq, 0);
    repeat (30) @(negedge clk);
    chk(!scl_o, "R6 scl held", scl_o, 0);
    rd(2'd0, v); chk(v[4], "R6 still pending", v, 8'h12);
    wr(2'd0, 8'h32);
    rd(2'd0, v); chk(v == 8'h32, "R3 write 1 keeps pending", v, 8'h32);
    chk(irq, "R8 irq on", irq, 1);

    wr(2'd3, 8'hC3);
    clr_cap();
    wr(2'd0, 8'h20);
    repeat (40) @(negedge clk);
    wr(2'd3, 8'h00);
    wait_pend(ok);
    chk(ok && cap == 8'hC3, "R9 busy data write ignored", cap, 8'hC3);

    for (int k = 0; k < 4; k++) begin
      sda_i = VEC[k][8];
      wr(2'd3, VEC[k][7:0]);
      clr_cap();
      wr(2'd0, 8'h20);
      wait_pend(ok);
      chk(ok && cap == VEC[k][7:0] && cap_n == 8, "R5 table byte", cap, VEC[k][7:0]);
      rd(2'd1, v); chk(v[0] == VEC[k][8], "R6 table ack", v[0], VEC[k][8]);
      chk(irq, "R8 table irq", irq, 1);
    end

    sda_i = 1'b0;
    wr(2'd3, 8'h96);
    clr_cap();
    wr(2'd0, 8'h20);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h30;
    ok = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      rd(2'd0, v);
      if (v[4]) begin ok = 1'b1; break; end
    end
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    rd(2'd0, v);
    chk(ok && v == 8'h30, "R12 set beats write", v, 8'h30);
    chk(irq && cap == 8'h96, "R12 byte and irq", cap, 8'h96);

    wr(2'd1, 8'hD0);
    wr(2'd0, 8'h20);
    ok = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      rd(2'd1, v);
      if (!v[5]) begin ok = 1'b1; break; end
    end
    chk(ok && stop_n == 1, "R10 stop seen", stop_n, 1);
    rd(2'd1, v); chk(v == 8'hD0, "R10 status after stop", v, 8'hD0);
    repeat (10) @(negedge clk);
    chk(scl_o && sda_o, "R10 lines high", {scl_o, sda_o}, 2'b11);
    chk(start_n == 1, "R11 no stray start", start_n, 1);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule